// File: doc/BRIEF.md
# Interpolated Short-Table Sine Lookup

This block turns a 16-bit phase word into an 8-bit sine amplitude. It stores only 32 waveform points, and it uses linear interpolation between neighbouring points to produce values in between. The phase word has the same meaning as the one that addresses a 256-point table. An accumulator built for that larger table can therefore drive this block unchanged. The frequency word, the sample rate and the frequency resolution all stay the same.

The five most significant phase bits select a base point. The point after it, wrapping past the last one, is the far end of the interpolation segment. The next eight phase bits give the fractional position along that segment. A valid strobe comes with each phase word. Two clocks later the block presents the interpolated amplitude together with its own valid flag. A new phase word may be accepted on every clock. The phase accumulator and the output converter are outside this block.

Top module: `sine_interp_lookup`

## Requirements
- R1: The stored point index is phase bits [15:11]. A phase whose bits [10:0] are all zero outputs stored point T[index] exactly, so phase 0x0800*k gives T[k].
- R2: Stored point T[k] for k = 0..31 equals 128 + floor(127*sin(2*pi*k/32) + 0.5). This gives T[0]=128, T[8]=255, T[16]=128 and T[24]=1.
- R3: The interpolation fraction is phase bits [10:3], an unsigned weight out of 256. Phase bits [2:0] have no effect on the output.
- R4: The far end of the segment is T[(index+1) mod 32]. With index 31 the far end is T[0].
- R5: The output equals T[index] + floor((T[next] - T[index]) * fraction / 256), where the difference is signed.
- R6: Every output lies between T[index] and T[next], inclusive.
- R7: Each phase word accepted with the valid input high produces exactly one output with the valid output high. That output appears in the second clock after the accepted word. Words accepted on consecutive clocks give outputs on consecutive clocks, in the same order.
- R8: While the valid output is low, the amplitude output holds its last value, whatever the phase input does.
- R9: After reset, the amplitude output is 0 and the valid output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| phaseIn | input | 16 | Phase word; bits [15:11] index, [10:3] fraction, [2:0] unused |
| phaseValid | input | 1 | Accept phaseIn on this clock |
| ampOut | output | 8 | Interpolated unsigned amplitude, mid-scale 128 |
| ampValid | output | 1 | ampOut carries a new result |

## Verification
The bench aims at the wrap from the last stored point back to the first. A design that forgot the modulo there would interpolate toward a wrong or undefined point near phase 0xF800. It also aims at falling segments, where the signed difference is negative. An unsigned or wrongly rounded product there would send the result far outside the two points, or leave it one code off. The three discarded low phase bits and point-aligned phases are checked to catch a fraction taken from the wrong bit field. Streams of words on consecutive clocks, idle gaps with a changing phase, and hold behaviour expose any latency other than two clocks, dropped or repeated valid pulses, and an output that drifts while idle.

// File: rtl/sine_interp_pkg.sv
package sine_interp_pkg;

  localparam int PHASE_W   = 16;
  localparam int IDX_W     = 5;
  localparam int FRAC_W    = 8;
  localparam int AMP_W     = 8;
  localparam int TABLE_LEN = 1 << IDX_W;
  localparam int DROP_W    = PHASE_W - IDX_W - FRAC_W;

  typedef struct packed {
    logic loadFetch;
    logic loadResult;
  } stageStrobes_t;

  // Quarter-wave magnitude above mid-scale, points 0..8 of a 32-point cycle.
  function automatic logic [AMP_W-1:0] quarterPoint(input logic [3:0] off);
    logic [AMP_W-1:0] v;
    case (off)
      4'd0:    v = 8'd128;
      4'd1:    v = 8'd153;
      4'd2:    v = 8'd177;
      4'd3:    v = 8'd199;
      4'd4:    v = 8'd218;
      4'd5:    v = 8'd234;
      4'd6:    v = 8'd245;
      4'd7:    v = 8'd253;
      default: v = 8'd255;
    endcase
    return v;
  endfunction

  // Full-cycle point from quarter-wave symmetry.
  function automatic logic [AMP_W-1:0] sinePoint(input logic [IDX_W-1:0] k);
    logic [3:0]       off;
    logic [AMP_W-1:0] q;
    logic [AMP_W:0]   neg;
    off = {1'b0, k[2:0]};
    if (k[3]) q = quarterPoint(4'd8 - off);
    else      q = quarterPoint(off);
    neg = 9'd256 - {1'b0, q};
    if (k[4]) return neg[AMP_W-1:0];
    else      return q;
  endfunction

endpackage

// File: rtl/interp_ctrl.sv
module interp_ctrl
  import sine_interp_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          phaseValid,
  output stageStrobes_t strobes,
  output logic          ampValid
);

  logic fetchValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fetchValidQ <= 1'b0;
      ampValid    <= 1'b0;
    end else begin
      fetchValidQ <= phaseValid;
      ampValid    <= fetchValidQ;
    end
  end

  always_comb begin
    strobes.loadFetch  = phaseValid;
    strobes.loadResult = fetchValidQ;
  end

endmodule

// File: rtl/interp_datapath.sv
module interp_datapath
  import sine_interp_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int IW = IDX_W,
  parameter int FW = FRAC_W,
  parameter int AW = AMP_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  stageStrobes_t strobes,
  input  logic [PW-1:0] phaseIn,
  output logic [AW-1:0] ampOut,
  output logic [AW-1:0] baseQ,
  output logic [AW-1:0] nextQ,
  output logic [FW-1:0] fracQ
);

  localparam int IDX_LSB = PW - IW;
  localparam int FRAC_LSB = IDX_LSB - FW;
  localparam int PROD_W = AW + FW + 2;
  localparam int STEP_W = AW + 2;

  logic [IW-1:0] baseIdx;
  logic [IW-1:0] nextIdx;
  logic [FW-1:0] fracBits;

  assign baseIdx  = phaseIn[PW-1 -: IW];
  assign nextIdx  = baseIdx + 1'b1;
  assign fracBits = phaseIn[FRAC_LSB +: FW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      nextQ <= '0;
      fracQ <= '0;
    end else if (strobes.loadFetch) begin
      baseQ <= sinePoint(baseIdx);
      nextQ <= sinePoint(nextIdx);
      fracQ <= fracBits;
    end
  end

  logic signed [AW:0]       diff;
  logic signed [PROD_W-1:0] prod;
  logic signed [STEP_W-1:0] step;
  logic signed [STEP_W-1:0] sum;

  always_comb begin
    diff = $signed({1'b0, nextQ}) - $signed({1'b0, baseQ});
    prod = diff * $signed({1'b0, fracQ});
    step = prod[FW +: STEP_W];
    sum  = $signed({2'b00, baseQ}) + step;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ampOut <= '0;
    end else if (strobes.loadResult) begin
      ampOut <= sum[AW-1:0];
    end
  end

endmodule

// File: rtl/sine_interp_lookup.sv
module sine_interp_lookup
  import sine_interp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] phaseIn,
  input  logic        phaseValid,
  output logic [7:0]  ampOut,
  output logic        ampValid
);

  stageStrobes_t   strobes;
  logic [AMP_W-1:0]  baseTap;
  logic [AMP_W-1:0]  nextTap;
  logic [FRAC_W-1:0] fracTap;

  interp_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .phaseValid (phaseValid),
    .strobes    (strobes),
    .ampValid   (ampValid)
  );

  interp_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .phaseIn (phaseIn),
    .ampOut  (ampOut),
    .baseQ   (baseTap),
    .nextQ   (nextTap),
    .fracQ   (fracTap)
  );

endmodule

// File: rtl/sine_interp_lookup_chk.sv
module sine_interp_lookup_chk (
  input logic       clk,
  input logic       rstN,
  input logic       phaseValid,
  input logic [7:0] ampOut,
  input logic       ampValid,
  input logic [7:0] baseTap,
  input logic [7:0] nextTap,
  input logic [7:0] fracTap
);

  logic [1:0] validPipe;

  always_ff @(posedge clk) begin
    if (!rstN) validPipe <= 2'b00;
    else       validPipe <= {validPipe[0], phaseValid};
  end

  AST_TWO_CLOCK_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ampValid == validPipe[1]); // R7

  AST_WITHIN_SEGMENT: assert property (@(posedge clk) disable iff (!rstN)
    ampValid |-> ((ampOut >= $past(baseTap) && ampOut <= $past(nextTap)) ||
                  (ampOut <= $past(baseTap) && ampOut >= $past(nextTap)))); // R6

  AST_ZERO_WEIGHT_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    (ampValid && $past(fracTap) == 8'd0) |-> ampOut == $past(baseTap)); // R1

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ampValid |-> $stable(ampOut)); // R8

endmodule

bind sine_interp_lookup sine_interp_lookup_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .phaseValid (phaseValid),
  .ampOut     (ampOut),
  .ampValid   (ampValid),
  .baseTap    (baseTap),
  .nextTap    (nextTap),
  .fracTap    (fracTap)
);

// File: tb/sine_interp_lookup_tb.sv
module sine_interp_lookup_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] phaseIn = '0;
  logic        phaseValid = 1'b0;
  logic [7:0]  ampOut;
  logic        ampValid;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sine_interp_lookup u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .phaseIn    (phaseIn),
    .phaseValid (phaseValid),
    .ampOut     (ampOut),
    .ampValid   (ampValid)
  );

  function automatic int refPoint(int k);
    real v;
    v = 127.0 * $sin(2.0 * 3.14159265358979 * k / 32.0);
    return 128 + $rtoi($floor(v + 0.5));
  endfunction

  function automatic int refAmp(int ph);
    int idx, nx, fr, y0, y1;
    idx = (ph >> 11) & 31;
    nx  = (idx + 1) % 32;
    fr  = (ph >> 3) & 255;
    y0  = refPoint(idx);
    y1  = refPoint(nx);
    return y0 + (((y1 - y0) * fr) >>> 8);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One word in, result sampled two clocks later.
  task automatic sendOne(input logic [15:0] ph, output int res);
    @(negedge clk);
    phaseIn = ph;
    phaseValid = 1'b1;
    @(negedge clk);
    phaseValid = 1'b0;
    check("R7 valid low after one clock", int'(ampValid), 0);
    @(negedge clk);
    check("R7 valid high after two clocks", int'(ampValid), 1);
    res = int'(ampOut);
  endtask

  task automatic testReset();
    check("R9 reset amplitude", int'(ampOut), 0);
    check("R9 reset valid", int'(ampValid), 0);
  endtask

  task automatic testAligned();
    int r;
    for (int k = 0; k < 32; k++) begin
      sendOne(16'(k * 16'h0800), r);
      check("R1 R2 aligned point", r, refPoint(k));
    end
    sendOne(16'h4000, r);
    check("R2 peak point 8", r, 255);
    sendOne(16'hC000, r);
    check("R2 trough point 24", r, 1);
  endtask

  task automatic testFraction();
    int r;
    int phs[6] = '{16'h0400, 16'h07F8, 16'h0008, 16'h4400, 16'h8A50, 16'hC7F8};
    foreach (phs[i]) begin
      sendOne(16'(phs[i]), r);
      check("R5 interpolated value", r, refAmp(phs[i]));
    end
    sendOne(16'h07F8, r);
    check("R5 rising near end", r, 152);
    sendOne(16'h87F8, r);
    check("R5 falling floor", r, 103);
  endtask

  task automatic testWrap();
    int r;
    sendOne(16'hFC00, r);
    check("R4 wrap midpoint", r, refAmp(16'hFC00));
    check("R4 wrap toward point 0", r, 115);
    sendOne(16'hFFF8, r);
    check("R4 wrap end", r, refAmp(16'hFFF8));
  endtask

  task automatic testLowBits();
    int a, b;
    sendOne(16'h2A50, a);
    sendOne(16'h2A57, b);
    check("R3 low bits ignored", b, a);
    sendOne(16'h9007, b);
    check("R3 low bits on aligned point", b, refPoint(18));
  endtask

  task automatic testRange();
    int r, lo, hi, y0, y1;
    for (int k = 0; k < 32; k++) begin
      int ph;
      ph = k * 2048 + 1016;
      sendOne(16'(ph), r);
      y0 = refPoint(k);
      y1 = refPoint((k + 1) % 32);
      lo = (y0 < y1) ? y0 : y1;
      hi = (y0 < y1) ? y1 : y0;
      check("R6 within segment", int'(r >= lo && r <= hi), 1);
    end
  endtask

  task automatic testStream();
    int exp[10];
    for (int i = 0; i < 10; i++) exp[i] = refAmp(i * 6553 + 5);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check("R7 stream valid", int'(ampValid), 1);
        check("R7 stream order", int'(ampOut), exp[i-2]);
      end
      if (i < 10) begin
        phaseIn = 16'(i * 6553 + 5);
        phaseValid = 1'b1;
      end else begin
        phaseValid = 1'b0;
      end
    end
    @(negedge clk);
    check("R7 stream ends", int'(ampValid), 0);
  endtask

  task automatic testHold();
    int r;
    sendOne(16'h1234, r);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      phaseIn = 16'(16'h9999 + i * 16'h1111);
      check("R8 idle valid low", int'(ampValid), 0);
      check("R8 idle hold", int'(ampOut), refAmp(16'h1234));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAligned();
    testFraction();
    testWrap();
    testLowBits();
    testRange();
    testStream();
    testHold();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule